// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by reading a two-level page table that sits in memory. A requester presents the physical address of the top-level directory, the virtual address and the kind of access (read, write or execute). The walker fetches the directory entry, then the table entry. It checks the presence and permission flags and answers with either a physical address or a fault code. Pages are 4 KiB. Each level holds 1024 entries of four bytes.

The walker uses one word-wide memory port with a req/ack handshake. When a write goes through a table entry whose dirty flag is clear, the walker writes that entry back with the dirty flag set before it answers. It handles one translation at a time.

The control is a five-state machine:

| State | What happens | Next state |
|---|---|---|
| `ST_IDLE` | Waits for a request. | `ST_DIR_FETCH` on an accepted request. |
| `ST_DIR_FETCH` | Reads the directory entry. | On ack: `ST_TBL_FETCH` if the entry is present, else `ST_RESPOND`. |
| `ST_TBL_FETCH` | Reads the table entry. | On ack: `ST_DIRTY_WB` for a permitted write through a clean entry, else `ST_RESPOND`. |
| `ST_DIRTY_WB` | Writes the table entry back with the dirty flag set. | `ST_RESPOND` on ack. |
| `ST_RESPOND` | Pulses the result for one cycle. | `ST_IDLE`. |

Top module: `pt_walker`

## Requirements
- R1: The virtual address splits into a directory index in bits 31:22, a table index in bits 21:12 and a byte offset in bits 11:0. The first memory read of a walk is at `base_addr + 4*directory index`. The base is latched when the request is accepted.
- R2: The second read is at (directory entry bits 31:12) << 12 plus 4 × table index.
- R3: Entry layout: frame number in bits 31:12, valid in bit 0, read in bit 1, write in bit 2, execute in bit 3, dirty in bit 4. A successful walk returns `resp_paddr` = (table entry frame << 12) OR offset, with `resp_fault` = 0 (none).
- R4: A directory entry with valid clear ends the walk after one read. The result is `resp_fault` = 1 (not present) and `resp_paddr` = 0.
- R5: A table entry with valid clear ends the walk with `resp_fault` = 1 and `resp_paddr` = 0.
- R6: Access kind codes are 0 = read, 1 = write and 2 = execute. A kind needs, in turn, the read, write or execute flag of the table entry. Code 3 is never permitted. A kind that is not permitted gives `resp_fault` = 2 (protection) and `resp_paddr` = 0.
- R7: A permitted write through a table entry whose dirty flag is clear causes one memory write before `done`. The write goes to the table entry's own address, and its data is that entry with bit 4 set and all other bits unchanged.
- R8: No memory write occurs for a read, for an execute, for a write whose entry is already dirty, or for a faulting access.
- R9: `busy` is high from the cycle after a request is accepted through the `done` cycle. A `req_valid` seen while `busy` is high is ignored.
- R10: `done` is high for exactly one cycle per walk. While `mem_ack` is low, `mem_req` stays high with `mem_addr` and `mem_we` held.
- R11: After reset `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | 32 | Physical address of the directory |
| req_valid | input | 1 | Translation request, taken when not busy |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| resp_paddr | output | 32 | Physical address, zero on a fault |
| resp_fault | output | 2 | 0 none, 1 not present, 2 protection |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Write data (entry with dirty set) |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
Translations are tried under two directory bases, on a clean read-write page, a read-only page, an execute page and an already-dirty page, with every access kind including the illegal code. The base change separates correct latching of the base from a fixed address path. The clean-versus-dirty writes separate a missing write-back from a spurious one. Entries whose valid bit is clear at either level, but whose other bits are nonzero, show that presence is tested before permission and that the walk stops at the right depth. A request held high during a walk checks that the block takes one request at a time.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
    localparam int ADDR_W    = 32;
    localparam int OFF_W     = 12;
    localparam int IDX_W     = 10;
    localparam int ENT_SHIFT = 2;
    localparam int FRAME_W   = ADDR_W - OFF_W;
    localparam int FLAG_W    = 5;

    localparam int BIT_V = 0;
    localparam int BIT_R = 1;
    localparam int BIT_W = 2;
    localparam int BIT_X = 3;
    localparam int BIT_D = 4;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_BAD   = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE        = 2'd0,
        FLT_NOT_PRESENT = 2'd1,
        FLT_PROTECT     = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_FETCH,
        ST_TBL_FETCH,
        ST_DIRTY_WB,
        ST_RESPOND
    } walk_state_e;
endpackage

// File: rtl/pt_walker_addr.sv
module pt_walker_addr #(
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 12,
    parameter int IDX_W     = 10,
    parameter int ENT_SHIFT = 2
) (
    input  logic [ADDR_W-1:0]       base,
    input  logic [ADDR_W-OFF_W-1:0] vpage,
    input  logic [ADDR_W-OFF_W-1:0] dir_frame,
    input  logic                    sel_table,
    output logic [ADDR_W-1:0]       addr
);
    localparam int VP_W = ADDR_W - OFF_W;

    logic [IDX_W-1:0]  dir_idx;
    logic [IDX_W-1:0]  tbl_idx;
    logic [ADDR_W-1:0] dir_addr;
    logic [ADDR_W-1:0] tbl_addr;

    assign dir_idx  = vpage[VP_W-1 -: IDX_W];
    assign tbl_idx  = vpage[IDX_W-1:0];
    assign dir_addr = base + (ADDR_W'(dir_idx) << ENT_SHIFT);
    assign tbl_addr = {dir_frame, {OFF_W{1'b0}}} + (ADDR_W'(tbl_idx) << ENT_SHIFT);
    assign addr     = sel_table ? tbl_addr : dir_addr;
endmodule

// File: rtl/pt_walker_check.sv
module pt_walker_check
    import pt_walker_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  acc_kind_e         kind,
    output logic              present,
    output logic              allowed,
    output logic              need_wb
);
    always_comb begin
        present = flags[BIT_V];
        unique case (kind)
            ACC_READ:  allowed = flags[BIT_R];
            ACC_WRITE: allowed = flags[BIT_W];
            ACC_EXEC:  allowed = flags[BIT_X];
            default:   allowed = 1'b0;
        endcase
        need_wb = present && allowed && (kind == ACC_WRITE) && !flags[BIT_D];
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_kind,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] resp_paddr,
    output logic [1:0]        resp_fault,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata
);
    walk_state_e        state, next_state;
    logic [ADDR_W-1:0]  base_q, vaddr_q, pte_q;
    logic [FRAME_W-1:0] dir_frame_q;
    acc_kind_e          kind_q;
    fault_e             fault_q;
    logic               ent_present, ent_allowed, ent_need_wb;

    pt_walker_addr #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_SHIFT(ENT_SHIFT)
    ) u_addr (
        .base      (base_q),
        .vpage     (vaddr_q[ADDR_W-1:OFF_W]),
        .dir_frame (dir_frame_q),
        .sel_table (state != ST_DIR_FETCH),
        .addr      (mem_addr)
    );

    pt_walker_check u_check (
        .flags   (mem_rdata[FLAG_W-1:0]),
        .kind    (kind_q),
        .present (ent_present),
        .allowed (ent_allowed),
        .need_wb (ent_need_wb)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    // transitions
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:      if (req_valid) next_state = ST_DIR_FETCH;
            ST_DIR_FETCH: if (mem_ack) next_state = ent_present ? ST_TBL_FETCH : ST_RESPOND;
            ST_TBL_FETCH: if (mem_ack) next_state = ent_need_wb ? ST_DIRTY_WB : ST_RESPOND;
            ST_DIRTY_WB:  if (mem_ack) next_state = ST_RESPOND;
            ST_RESPOND:   next_state = ST_IDLE;
            default:      next_state = ST_IDLE;
        endcase
    end

    // walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q      <= '0;
            vaddr_q     <= '0;
            kind_q      <= ACC_READ;
            dir_frame_q <= '0;
            pte_q       <= '0;
            fault_q     <= FLT_NONE;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    base_q  <= base_addr;
                    vaddr_q <= req_vaddr;
                    kind_q  <= acc_kind_e'(req_kind);
                    fault_q <= FLT_NONE;
                end
                ST_DIR_FETCH: if (mem_ack) begin
                    dir_frame_q <= mem_rdata[ADDR_W-1:OFF_W];
                    fault_q     <= ent_present ? FLT_NONE : FLT_NOT_PRESENT;
                end
                ST_TBL_FETCH: if (mem_ack) begin
                    pte_q <= mem_rdata;
                    if (!ent_present)      fault_q <= FLT_NOT_PRESENT;
                    else if (!ent_allowed) fault_q <= FLT_PROTECT;
                    else                   fault_q <= FLT_NONE;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        done       = (state == ST_RESPOND);
        mem_req    = (state == ST_DIR_FETCH) || (state == ST_TBL_FETCH) || (state == ST_DIRTY_WB);
        mem_we     = (state == ST_DIRTY_WB);
        mem_wdata  = pte_q | (ADDR_W'(1) << BIT_D);
        resp_fault = done ? fault_q : FLT_NONE;
        resp_paddr = (done && fault_q == FLT_NONE) ?
                     {pte_q[ADDR_W-1:OFF_W], vaddr_q[OFF_W-1:0]} : '0;
    end

    // R9
    busy_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (!busy && req_valid) |=> busy);
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R7
    wb_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_we) |-> mem_wdata[BIT_D]);
    // R8
    wb_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we) |-> $past(mem_ack));
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_addr = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        busy, done, mem_req, mem_we;
    logic [31:0] resp_paddr, mem_addr, mem_wdata;
    logic [1:0]  resp_fault;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2 clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .req_valid(req_valid),
        .req_vaddr(req_vaddr), .req_kind(req_kind), .busy(busy), .done(done),
        .resp_paddr(resp_paddr), .resp_fault(resp_fault), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int fails = 0;
    int wr_count = 0;
    int done_count = 0;
    logic [31:0] last_wr_addr = '0;
    logic [31:0] mem [int unsigned];
    logic [31:0] rd_log [$];
    logic [31:0] exp_paddr_q [$];
    logic [1:0]  exp_fault_q [$];
    string       exp_tag_q [$];

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model, driven away from the active edge
    always @(negedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                wr_count++;
                last_wr_addr = mem_addr;
            end else begin
                mem_rdata <= rd(mem_addr);
                rd_log.push_back(mem_addr);
            end
            mem_ack <= 1'b1;
        end else mem_ack <= 1'b0;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            done_count++;
            if (exp_tag_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9 unexpected result actual=%h expected=none", resp_paddr);
            end else begin
                automatic string t = exp_tag_q.pop_front();
                automatic logic [31:0] ep = exp_paddr_q.pop_front();
                automatic logic [1:0]  ef = exp_fault_q.pop_front();
                check({t, " paddr"}, resp_paddr, ep);
                check({t, " fault"}, 32'(resp_fault), 32'(ef));
            end
        end
    end

    task automatic walk(input logic [31:0] va, input logic [1:0] kind,
                        input logic [31:0] ep, input logic [1:0] ef, input string tag);
        exp_paddr_q.push_back(ep);
        exp_fault_q.push_back(ef);
        exp_tag_q.push_back(tag);
        rd_log.delete();
        @(negedge clk);
        req_vaddr = va; req_kind = kind; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    bit finished = 0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int wc, dc;
        mem[32'h10005718] = 32'h12345001;
        mem[32'h123454a8] = 32'h14817007;
        mem[32'h123454ac] = 32'h22222003;
        mem[32'h123454b0] = 32'h3333300b;
        mem[32'h123454b4] = 32'h66666016;
        mem[32'h10005004] = 32'h55555000;
        mem[32'h20000718] = 32'h44444001;
        mem[32'h444444a8] = 32'h77777017;
        base_addr = 32'h10005000;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 busy", 32'(busy), 0);
        check("R11 done", 32'(done), 0);
        check("R11 mem_req", 32'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R7: first write to clean page
        dc = done_count;
        walk(32'h7192a44c, 2'd1, 32'h1481744c, 2'd0, "R3 write clean");
        check("R1 dir read addr", rd_log[0], 32'h10005718);
        check("R2 tbl read addr", rd_log[1], 32'h123454a8);
        check("R7 wb count", 32'(wr_count), 1);
        check("R7 wb addr", last_wr_addr, 32'h123454a8);
        check("R7 wb data", rd(32'h123454a8), 32'h14817017);
        check("R10 one done", 32'(done_count - dc), 1);

        // R8 write again, now dirty
        walk(32'h7192a44c, 2'd1, 32'h1481744c, 2'd0, "R8 write dirty");
        check("R8 no wb dirty", 32'(wr_count), 1);

        // R6 exec on non-exec page, read ok
        walk(32'h7192a44c, 2'd2, 32'h0, 2'd2, "R6 exec denied");
        walk(32'h7192a44c, 2'd3, 32'h0, 2'd2, "R6 bad kind");
        walk(32'h7192b010, 2'd0, 32'h22222010, 2'd0, "R3 read ro");
        check("R2 tbl read ro", rd_log[1], 32'h123454ac);
        walk(32'h7192b010, 2'd1, 32'h0, 2'd2, "R6 write ro");
        check("R8 no wb on fault", 32'(wr_count), 1);
        walk(32'h7192c800, 2'd2, 32'h33333800, 2'd0, "R6 exec ok");
        check("R8 no wb on exec", 32'(wr_count), 1);

        // R4 R5 not present
        walk(32'h00400123, 2'd0, 32'h0, 2'd1, "R4 dir invalid");
        check("R4 one read", 32'(rd_log.size()), 1);
        check("R1 dir idx 1", rd_log[0], 32'h10005004);
        walk(32'h7192d000, 2'd1, 32'h0, 2'd1, "R5 tbl invalid");
        check("R8 no wb invalid", 32'(wr_count), 1);

        // R1 other base, R8 dirty entry write
        base_addr = 32'h20000000;
        walk(32'h7192a44c, 2'd1, 32'h7777744c, 2'd0, "R1 new base");
        check("R1 new base addr", rd_log[0], 32'h20000718);
        check("R8 no wb preset dirty", 32'(wr_count), 1);

        // R9 request during busy ignored
        base_addr = 32'h10005000;
        dc = done_count;
        wc = wr_count;
        exp_paddr_q.push_back(32'h22222010);
        exp_fault_q.push_back(2'd0);
        exp_tag_q.push_back("R9 first of overlap");
        @(negedge clk);
        req_vaddr = 32'h7192b010; req_kind = 2'd0; req_valid = 1'b1;
        @(negedge clk);
        check("R9 busy after accept", 32'(busy), 1);
        req_vaddr = 32'h7192a44c; req_kind = 2'd1;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (6) @(negedge clk);
        check("R9 single result", 32'(done_count - dc), 1);
        check("R9 no extra walk", 32'(wr_count - wc), 0);
        check("R9 busy idle", 32'(busy), 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule